// File: doc/BRIEF.md
# Wrapping Address Register Unit

This block keeps the pointer state of a small DSP address generator. It has four address slots. Each slot holds a 16-bit address, a signed step called the index, and a wrap mask. On request the block moves an address by plus one, by minus one, or by adding its slot's index. The plus-one and minus-one moves stay inside a circular window that the wrap mask selects. A mask of all ones makes those moves ordinary modulo-2^16 arithmetic. The block never touches the program counter. It only advances the data pointers that the surrounding datapath uses.

A configuration port loads and reads any address, index or mask. Two update ports, A and B, can each request a move on any slot in the same cycle. All current addresses are always visible on a flat output bus. If both ports target the same slot in one cycle, that is a protocol error. The block resolves it in favour of port A and raises a one-cycle flag.

Top module: `addr_wrap_unit`

## Requirements
- R1: After synchronous reset every address and every index reads 0, and every wrap mask reads all ones (0xFFFF).
- R2: The configuration port selects a bank with `cfg_bank` (0 = address, 1 = index, 2 = wrap mask, 3 = none) and a slot with `cfg_idx`. A write with `cfg_we` takes effect at the next edge. `cfg_rdata` shows the selected value combinationally. Bank 3 reads 0, and writes to it change nothing.
- R3: Op code 0 (step up): if every bit set in the mask is also set in the address, those masked bits become 0 and the other bits are kept. Otherwise the address becomes address + 1, modulo 2^16.
- R4: Op code 1 (step down): if the address AND the mask is zero, the address becomes address OR mask. Otherwise it becomes address − 1, modulo 2^16.
- R5: Op code 2 adds the slot's index to the address as a signed 16-bit value, modulo 2^16, whatever the mask holds.
- R6: Op code 3, and any slot with no request, leaves the address unchanged.
- R7: Requests on ports A and B for different slots are both applied at the same edge. The new addresses appear on `addr_o` (slot n in bits 16n+15..16n) in the next cycle.
- R8: If A and B request the same slot in one cycle, only A's move is applied, and `conflict_o` is 1 for exactly the following cycle.
- R9: A configuration write to a slot's address in the same cycle as a move on that slot wins: the written value is stored.
- R10: Moves use the index and mask held before the edge. A same-cycle configuration write to either one affects only later moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank select: 0 address, 1 index, 2 wrap mask, 3 none |
| cfg_idx | input | 2 | Slot select for configuration |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Selected register value, combinational |
| upd_a_valid | input | 1 | Port A move request |
| upd_a_idx | input | 2 | Port A slot |
| upd_a_op | input | 2 | Port A op code (0 up, 1 down, 2 add index, 3 hold) |
| upd_b_valid | input | 1 | Port B move request |
| upd_b_idx | input | 2 | Port B slot |
| upd_b_op | input | 2 | Port B op code |
| addr_o | output | 64 | All current addresses, slot n at bits 16n+15..16n |
| conflict_o | output | 1 | One-cycle flag for a same-slot collision in the previous cycle |

## Verification
The bench builds the block with its defaults: 16-bit registers and four slots. With 16-bit registers, the modulo boundaries 0xFFFF to 0x0000 and back, and negative indices, can be reached with single configuration writes. With four slots, every slot, both ports at once and every collision pairing can be exercised. Masks that are not all ones, such as 0x0007, bring the window wrap within a few steps of any start value. A mirror model in the bench predicts every address after each cycle, and it also predicts the collision flag.

// File: rtl/awu_pkg.sv
package awu_pkg;

    typedef enum logic [1:0] {
        AWU_UP   = 2'd0,
        AWU_DOWN = 2'd1,
        AWU_ADDX = 2'd2,
        AWU_HOLD = 2'd3
    } awu_op_e;

    typedef enum logic [1:0] {
        BK_ADDR  = 2'd0,
        BK_INDEX = 2'd1,
        BK_WRAP  = 2'd2,
        BK_NONE  = 2'd3
    } awu_bank_e;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/awu_step.sv
module awu_step
    import awu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] ar,
    input  logic [DATA_W-1:0] ix,
    input  logic [DATA_W-1:0] wr,
    input  awu_op_e           op,
    output logic [DATA_W-1:0] nxt
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic top_hit;
    logic floor_hit;

    assign top_hit   = ((ar & wr) == wr);
    assign floor_hit = ((ar & wr) == '0);

    always_comb begin
        unique case (op)
            AWU_UP:   nxt = top_hit ? (ar & ~wr) : (ar + ONE);
            AWU_DOWN: nxt = floor_hit ? (ar | wr) : (ar - ONE);
            AWU_ADDX: nxt = ar + ix;
            default:  nxt = ar;
        endcase
    end

    // With a full mask the window moves collapse to linear arithmetic
    always_comb begin
        if (op == AWU_UP && wr == '1)
            p_up_linear_r3: assert (nxt == ar + ONE);
        if (op == AWU_DOWN && wr == '1)
            p_down_linear_r4: assert (nxt == ar - ONE);
    end

endmodule

// File: rtl/awu_slot.sv
module awu_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_val,
    input  logic              ar_we,
    input  logic              ix_we,
    input  logic              wr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ar_o,
    output logic [DATA_W-1:0] ix_o,
    output logic [DATA_W-1:0] wr_o
);

    logic [DATA_W-1:0] ar_q, ix_q, wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
            ix_q <= '0;
            wr_q <= '1;
        end else begin
            if (ar_we)
                ar_q <= wdata;
            else if (upd_en)
                ar_q <= upd_val;
            if (ix_we)
                ix_q <= wdata;
            if (wr_we)
                wr_q <= wdata;
        end
    end

    assign ar_o = ar_q;
    assign ix_o = ix_q;
    assign wr_o = wr_q;

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !ar_we) |=> $stable(ar_o));

    p_cfg_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ar_we |=> (ar_o == $past(wdata)));

    p_mask_kept_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_we |=> $stable(wr_o));

endmodule

// File: rtl/addr_wrap_unit.sv
module addr_wrap_unit
    import awu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_bank,
    input  logic [$clog2(NUM_REGS)-1:0]  cfg_idx,
    input  logic [DATA_W-1:0]            cfg_wdata,
    output logic [DATA_W-1:0]            cfg_rdata,
    input  logic                         upd_a_valid,
    input  logic [$clog2(NUM_REGS)-1:0]  upd_a_idx,
    input  logic [1:0]                   upd_a_op,
    input  logic                         upd_b_valid,
    input  logic [$clog2(NUM_REGS)-1:0]  upd_b_idx,
    input  logic [1:0]                   upd_b_op,
    output logic [NUM_REGS*DATA_W-1:0]   addr_o,
    output logic                         conflict_o
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] ar_q [NUM_REGS];
    logic [DATA_W-1:0] ix_q [NUM_REGS];
    logic [DATA_W-1:0] wr_q [NUM_REGS];

    logic             p_valid [NUM_PORTS];
    logic [IDX_W-1:0] p_idx   [NUM_PORTS];
    awu_op_e          p_op    [NUM_PORTS];
    logic [DATA_W-1:0] p_nxt  [NUM_PORTS];

    logic      same_slot;
    logic      conflict_q;
    awu_bank_e bank;

    assign same_slot = upd_a_valid && upd_b_valid && (upd_a_idx == upd_b_idx);
    assign bank      = awu_bank_e'(cfg_bank);

    // Port A has priority; port B is dropped on a collision
    assign p_valid[0] = upd_a_valid;
    assign p_idx[0]   = upd_a_idx;
    assign p_op[0]    = awu_op_e'(upd_a_op);
    assign p_valid[1] = upd_b_valid && !same_slot;
    assign p_idx[1]   = upd_b_idx;
    assign p_op[1]    = awu_op_e'(upd_b_op);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        awu_step #(.DATA_W(DATA_W)) u_step (
            .ar  (ar_q[p_idx[p]]),
            .ix  (ix_q[p_idx[p]]),
            .wr  (wr_q[p_idx[p]]),
            .op  (p_op[p]),
            .nxt (p_nxt[p])
        );
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        logic hit_a, hit_b;
        assign hit_a = p_valid[0] && (p_idx[0] == IDX_W'(i));
        assign hit_b = p_valid[1] && (p_idx[1] == IDX_W'(i));

        awu_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .upd_en  (hit_a || hit_b),
            .upd_val (hit_a ? p_nxt[0] : p_nxt[1]),
            .ar_we   (cfg_we && bank == BK_ADDR  && cfg_idx == IDX_W'(i)),
            .ix_we   (cfg_we && bank == BK_INDEX && cfg_idx == IDX_W'(i)),
            .wr_we   (cfg_we && bank == BK_WRAP  && cfg_idx == IDX_W'(i)),
            .wdata   (cfg_wdata),
            .ar_o    (ar_q[i]),
            .ix_o    (ix_q[i]),
            .wr_o    (wr_q[i])
        );

        assign addr_o[i*DATA_W +: DATA_W] = ar_q[i];
    end

    always_comb begin
        unique case (bank)
            BK_ADDR:  cfg_rdata = ar_q[cfg_idx];
            BK_INDEX: cfg_rdata = ix_q[cfg_idx];
            BK_WRAP:  cfg_rdata = wr_q[cfg_idx];
            default:  cfg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            conflict_q <= 1'b0;
        else
            conflict_q <= same_slot;
    end

    assign conflict_o = conflict_q;

    p_conflict_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_a_valid && upd_b_valid && upd_a_idx == upd_b_idx) |=> conflict_o);

    p_conflict_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !(upd_a_valid && upd_b_valid) |=> !conflict_o);

endmodule

// File: tb/addr_wrap_unit_bench.sv
`timescale 1ns/1ps
module addr_wrap_unit_bench;

    localparam int W = 16;
    localparam int N = 4;

    typedef struct packed {
        logic [N-1:0][W-1:0] ar;
        logic                conf;
        logic [7:0]          req;
    } exp_t;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we;
    logic [1:0] cfg_bank;
    logic [1:0] cfg_idx;
    logic [W-1:0] cfg_wdata;
    logic [W-1:0] cfg_rdata;
    logic upd_a_valid, upd_b_valid;
    logic [1:0] upd_a_idx, upd_b_idx, upd_a_op, upd_b_op;
    logic [N*W-1:0] addr_o;
    logic conflict_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    exp_t sb_q[$];
    logic [W-1:0] m_ar [N];
    logic [W-1:0] m_ix [N];
    logic [W-1:0] m_wr [N];

    always #2.5 clk = ~clk;

    addr_wrap_unit u_addr_wrap_unit (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .upd_a_valid(upd_a_valid), .upd_a_idx(upd_a_idx), .upd_a_op(upd_a_op),
        .upd_b_valid(upd_b_valid), .upd_b_idx(upd_b_idx), .upd_b_op(upd_b_op),
        .addr_o(addr_o), .conflict_o(conflict_o)
    );

    function automatic logic [W-1:0] model_move(logic [1:0] op, logic [W-1:0] a,
                                                logic [W-1:0] x, logic [W-1:0] m);
        case (op)
            2'd0: return ((a & m) == m) ? (a & ~m) : a + 16'd1;   // R3
            2'd1: return ((a & m) == 16'd0) ? (a | m) : a - 16'd1; // R4
            2'd2: return a + x;                                   // R5
            default: return a;                                    // R6
        endcase
    endfunction

    // One cycle of stimulus; pushes the expected post-edge state
    task automatic cyc(input logic av, input logic [1:0] ai, input logic [1:0] ao,
                       input logic bv, input logic [1:0] bi, input logic [1:0] bo,
                       input logic cwe, input logic [1:0] cb, input logic [1:0] ci,
                       input logic [W-1:0] cd, input int req);
        exp_t e;
        logic [W-1:0] rd_exp;
        logic [W-1:0] nar [N];
        logic col;
        @(negedge clk);
        upd_a_valid = av; upd_a_idx = ai; upd_a_op = ao;
        upd_b_valid = bv; upd_b_idx = bi; upd_b_op = bo;
        cfg_we = cwe; cfg_bank = cb; cfg_idx = ci; cfg_wdata = cd;
        #1;
        // R2: combinational read of pre-edge state
        case (cb)
            2'd0: rd_exp = m_ar[ci];
            2'd1: rd_exp = m_ix[ci];
            2'd2: rd_exp = m_wr[ci];
            default: rd_exp = '0;
        endcase
        checks++;
        if (cfg_rdata !== rd_exp) begin
            failures++;
            $display("FAIL R2 read bank=%0d idx=%0d got=%h exp=%h", cb, ci, cfg_rdata, rd_exp);
        end
        for (int i = 0; i < N; i++) nar[i] = m_ar[i];
        col = av && bv && (ai == bi);
        if (bv && !col) nar[bi] = model_move(bo, m_ar[bi], m_ix[bi], m_wr[bi]);
        if (av) nar[ai] = model_move(ao, m_ar[ai], m_ix[ai], m_wr[ai]);
        if (cwe) begin
            if (cb == 2'd0) nar[ci] = cd;           // R9
            else if (cb == 2'd1) m_ix[ci] = cd;     // R10: after moves used old
            else if (cb == 2'd2) m_wr[ci] = cd;
        end
        for (int i = 0; i < N; i++) begin
            m_ar[i] = nar[i];
            e.ar[i] = nar[i];
        end
        e.conf = col;
        e.req = 8'(req);
        sb_q.push_back(e);
    endtask

    task automatic idle(input int req);
        cyc(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 16'h0, req);
    endtask

    task automatic wcfg(input logic [1:0] b, input logic [1:0] i, input logic [W-1:0] d, input int req);
        cyc(0, 0, 0, 0, 0, 0, 1, b, i, d, req);
    endtask

    task automatic mv(input logic [1:0] i, input logic [1:0] op, input int req);
        cyc(1, i, op, 0, 0, 0, 0, 2'd0, i, 16'h0, req);
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (addr_o !== e.ar || conflict_o !== e.conf) begin
                failures++;
                $display("FAIL R%0d addr=%h conf=%b exp addr=%h conf=%b",
                         e.req, addr_o, conflict_o, e.ar, e.conf);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_we = 0; cfg_bank = 0; cfg_idx = 0; cfg_wdata = 0;
        upd_a_valid = 0; upd_a_idx = 0; upd_a_op = 0;
        upd_b_valid = 0; upd_b_idx = 0; upd_b_op = 0;
        for (int i = 0; i < N; i++) begin m_ar[i] = 0; m_ix[i] = 0; m_wr[i] = 16'hFFFF; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values on every bank
        for (int i = 0; i < N; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 2'd1, 2'(i), 0, 1);
            cyc(0, 0, 0, 0, 0, 0, 0, 2'd2, 2'(i), 0, 1);
        end
        // R3: linear step up, then windowed step up with wrap
        wcfg(2'd0, 0, 16'h0010, 2);
        mv(0, 2'd0, 3);
        wcfg(2'd2, 1, 16'h0007, 2);
        wcfg(2'd0, 1, 16'h0105, 2);
        mv(1, 2'd0, 3);
        mv(1, 2'd0, 3);
        mv(1, 2'd0, 3);              // R3 wrap to 0x0100
        // R4: windowed step down wrap and plain step
        mv(1, 2'd1, 4);              // 0x0100 -> 0x0107
        mv(1, 2'd1, 4);
        mv(2, 2'd1, 4);              // 0x0000 -> 0xFFFF
        mv(2, 2'd0, 3);              // 0xFFFF -> 0x0000
        // R5: negative index, and add ignores mask
        wcfg(2'd1, 0, 16'hFFFD, 5);
        mv(0, 2'd2, 5);
        wcfg(2'd2, 0, 16'h0007, 5);
        wcfg(2'd0, 0, 16'h0006, 5);
        wcfg(2'd1, 0, 16'h0004, 5);
        mv(0, 2'd2, 5);              // 0x000A, no wrap
        // R6: hold op
        mv(1, 2'd3, 6);
        // R7: both ports, different slots
        cyc(1, 2, 2'd0, 1, 1, 2'd1, 0, 2'd0, 0, 0, 7);
        cyc(1, 3, 2'd1, 1, 0, 2'd2, 0, 2'd0, 0, 0, 7);
        // R8: collision, A wins, flag next cycle
        cyc(1, 2, 2'd0, 1, 2, 2'd1, 0, 2'd0, 2, 0, 8);
        idle(8);
        cyc(1, 1, 2'd1, 1, 1, 2'd0, 0, 2'd0, 1, 0, 8);
        // R9: config write beats move on same slot
        cyc(1, 3, 2'd0, 0, 0, 0, 1, 2'd0, 3, 16'hBEEF, 9);
        // R10: move uses pre-edge index and mask
        wcfg(2'd1, 2, 16'h0010, 10);
        cyc(1, 2, 2'd2, 0, 0, 0, 1, 2'd1, 2, 16'h0100, 10);
        mv(2, 2'd2, 10);
        cyc(1, 1, 2'd0, 0, 0, 0, 1, 2'd2, 1, 16'hFFFF, 10);
        // R2: bank 3 write ignored
        wcfg(2'd3, 0, 16'h1234, 2);
        for (int i = 0; i < N; i++) cyc(0, 0, 0, 0, 0, 0, 0, 2'd0, 2'(i), 0, 2);
        idle(6);
        idle(6);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule